// File: doc/BRIEF.md
# Custom-Opcode Interrupt Control Unit

This unit sits beside a small 32-bit RISC-V core and carries out the instructions the core finds in the custom-0 major opcode (7'h0b). The core hands over the already-split instruction fields and the two source operand values. In the same cycle the unit returns a result for the destination register, a write enable, a stall request and a return-from-interrupt strobe. It keeps the interrupt mask, the pending-interrupt vector, a down-counting timer and four shadow registers q0..q3. The core uses these shadows to save integer registers on entry to a handler.

Thirty-two external interrupt lines set pending bits. The core clears those bits through an acknowledge vector. The unit raises a request whenever a pending line is not masked. A parameter names lines that stay masked no matter what software writes. Each cycle with `issue_valid` high counts as one issued instruction. The one exception is wait-for-interrupt, which the core holds for as long as `stall` stays high.

Top module: `irq_cop`

## Requirements
- R1: Only instructions whose opcode field equals 7'b0001011 are recognised. Any other opcode gives rd_we=0, stall=0 and ret_pulse=0, and changes no mask, pending, timer or q state.
- R2: With funct3=0, funct7 selects the operation: 2 is return, 3 is mask update, 4 is wait, 5 is timer access. Any other funct7, and any funct3 other than 0, 2 or 3, is ignored with no write.
- R3: Mask update drives rd_data with the mask as it was before the instruction, with rd_we=1, in the issue cycle. From the next cycle the mask is ((mask & ~rs2_val) ^ rs1_val) | PERM_MASK.
- R4: Lines set in PERM_MASK always read back as masked and never cause irq_req, even when they are pending.
- R5: While no pending bit is unmasked, wait holds stall=1 and rd_we=0. If an unmasked pending bit is first visible in cycle t, then in cycle t+1 stall=0, rd_we=1 and rd_data is the pending vector.
- R6: Timer access drives rd_data with the count from before the instruction, with rd_we=1, and loads the count with rs1_val.
- R7: A nonzero count drops by one each clock. The clock edge that takes it from 1 to 0 also sets pending bit 0, unless a timer load happens in that cycle. A count of zero stays at zero, so loading zero disables the timer.
- R8: Return pulses ret_pulse for its issue cycle and never asserts rd_we or stall.
- R9: funct3=2 writes q[rd_idx mod 4] = rs1_val + sign-extended imm12 and keeps rd_we=0.
- R10: funct3=3 drives rd_data = q[rs1_idx mod 4] + sign-extended imm12 with rd_we=1.
- R11: An asserted irq_lines bit sets its pending bit at the next edge, and an irq_ack bit clears it. If both arrive in the same cycle, the set wins. irq_req is high exactly when some pending bit is unmasked.
- R12: Reset leaves the mask at all ones, pending at zero, the timer at zero and all q registers at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 7 | Major opcode field |
| funct3 | input | 3 | funct3 field |
| funct7 | input | 7 | funct7 field (R-type) |
| rd_idx | input | 5 | Destination register index |
| rs1_idx | input | 5 | First source register index |
| imm12 | input | 12 | I-type immediate |
| rs1_val | input | 32 | First source operand value |
| rs2_val | input | 32 | Second source operand value |
| irq_lines | input | 32 | External interrupt lines |
| irq_ack | input | 32 | Per-line pending clear from the core |
| rd_data | output | 32 | Result for the destination register |
| rd_we | output | 1 | Destination register write enable |
| stall | output | 1 | Core must hold the current instruction |
| ret_pulse | output | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Unmasked interrupt pending |

## Verification
Every stored value comes back to the core through one reply: mask and timer updates return the old value, wait returns the pending vector, and a q read returns the shadow. A corrupted register therefore shows up in the result of the next instruction that touches it, or at once on irq_req. A mask or pending error changes irq_req in the cycle after the edge that stored it. A timer that counts wrong moves the cycle in which irq_req rises, or leaves it low. The wait handshake is checked cycle by cycle, so a completion one cycle early or late is seen directly on stall and rd_we.

// File: rtl/irq_cop_pkg.sv
`timescale 1ns/1ps
package irq_cop_pkg;
    localparam int XLEN = 32;
    localparam int QNUM = 4;
    localparam int IMMW = 12;

    localparam logic [6:0] OPC_CUSTOM = 7'h0b;
    localparam logic [2:0] F3_RTYPE   = 3'd0;
    localparam logic [2:0] F3_QSET    = 3'd2;
    localparam logic [2:0] F3_QGET    = 3'd3;
    localparam logic [6:0] F7_RET     = 7'd2;
    localparam logic [6:0] F7_MASK    = 7'd3;
    localparam logic [6:0] F7_WAIT    = 7'd4;
    localparam logic [6:0] F7_TIMER   = 7'd5;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_RET   = 3'd1,
        OP_MASK  = 3'd2,
        OP_WAIT  = 3'd3,
        OP_TIMER = 3'd4,
        OP_QSET  = 3'd5,
        OP_QGET  = 3'd6
    } cop_op_e;
endpackage

// File: rtl/irq_cop_decode.sv
`timescale 1ns/1ps
module irq_cop_decode
    import irq_cop_pkg::*;
(
    input  logic       valid,
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output cop_op_e    op
);
    always_comb begin
        op = OP_NONE;
        if (valid && opcode == OPC_CUSTOM) begin
            unique case (funct3)
                F3_RTYPE: begin
                    unique case (funct7)
                        F7_RET:   op = OP_RET;
                        F7_MASK:  op = OP_MASK;
                        F7_WAIT:  op = OP_WAIT;
                        F7_TIMER: op = OP_TIMER;
                        default:  op = OP_NONE;
                    endcase
                end
                F3_QSET: op = OP_QSET;
                F3_QGET: op = OP_QGET;
                default: op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/irq_cop_irqctl.sv
`timescale 1ns/1ps
module irq_cop_irqctl #(
    parameter int               XLEN      = 32,
    parameter logic [XLEN-1:0]  PERM_MASK = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_wr,
    input  logic [XLEN-1:0] mask_flip,
    input  logic [XLEN-1:0] mask_keep_n,
    input  logic [XLEN-1:0] lines,
    input  logic [XLEN-1:0] ack,
    input  logic            tick,
    input  logic            wait_act,
    output logic [XLEN-1:0] mask_q,
    output logic [XLEN-1:0] pend_q,
    output logic            wake_q,
    output logic            irq_req
);
    typedef struct packed {
        logic [XLEN-1:0] mask;
        logic [XLEN-1:0] pend;
        logic            wake;
    } ctl_s;

    localparam ctl_s CTL_RST = '{mask: '1, pend: '0, wake: 1'b0};

    ctl_s s_d, s_q;
    logic live;

    assign live = |(s_q.pend & ~s_q.mask);

    always_comb begin
        s_d = s_q;
        if (mask_wr) begin
            s_d.mask = ((s_q.mask & ~mask_keep_n) ^ mask_flip) | PERM_MASK;
        end
        s_d.pend = (s_q.pend & ~ack) | lines | {{(XLEN-1){1'b0}}, tick};
        s_d.wake = wait_act & ~s_q.wake & live;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= CTL_RST | ctl_s'({PERM_MASK, {(XLEN+1){1'b0}}});
        else        s_q <= s_d;
    end

    assign mask_q  = s_q.mask;
    assign pend_q  = s_q.pend;
    assign wake_q  = s_q.wake;
    assign irq_req = live;

    // R4
    perm_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & PERM_MASK) == PERM_MASK);

    // R11
    line_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lines != '0) |=> ((pend_q & $past(lines)) == $past(lines)));

    // R7
    tick_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pend_q[0]);

    // R5
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_q) |-> $past(wait_act));
endmodule

// File: rtl/irq_cop_timer.sv
`timescale 1ns/1ps
module irq_cop_timer #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] load_val,
    output logic [XLEN-1:0] cnt_q,
    output logic            fire
);
    typedef struct packed {
        logic [XLEN-1:0] cnt;
    } tmr_s;

    tmr_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.cnt = load_val;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign cnt_q = t_q.cnt;
    assign fire  = !load && (t_q.cnt == XLEN'(1));

    // R7
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R7
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

    // R6
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/irq_cop_qregs.sv
`timescale 1ns/1ps
module irq_cop_qregs #(
    parameter int XLEN = 32,
    parameter int QNUM = 4,
    parameter int IDXW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [XLEN-1:0] wr_val,
    input  logic [IDXW-1:0] rd_idx,
    output logic [XLEN-1:0] rd_val
);
    typedef struct packed {
        logic [QNUM-1:0][XLEN-1:0] q;
    } qbank_s;

    qbank_s b_d, b_q;

    always_comb begin
        b_d = b_q;
        for (int i = 0; i < QNUM; i++) begin
            if (wr_en && (int'(wr_idx) % QNUM) == i) b_d.q[i] = wr_val;
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < QNUM; i++) begin
            if ((int'(rd_idx) % QNUM) == i) rd_val = b_q.q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    for (genvar g = 0; g < QNUM; g++) begin : g_slot
        // R9
        q_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (int'(wr_idx) % QNUM) == g) |=> (b_q.q[g] == $past(wr_val)));
        // R9
        q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (int'(wr_idx) % QNUM) == g) |=> $stable(b_q.q[g]));
    end
endmodule

// File: rtl/irq_cop.sv
`timescale 1ns/1ps
module irq_cop
    import irq_cop_pkg::*;
#(
    parameter logic [31:0] PERM_MASK = 32'hC000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        issue_valid,
    input  logic [6:0]  opcode,
    input  logic [2:0]  funct3,
    input  logic [6:0]  funct7,
    input  logic [4:0]  rd_idx,
    input  logic [4:0]  rs1_idx,
    input  logic [11:0] imm12,
    input  logic [31:0] rs1_val,
    input  logic [31:0] rs2_val,
    input  logic [31:0] irq_lines,
    input  logic [31:0] irq_ack,
    output logic [31:0] rd_data,
    output logic        rd_we,
    output logic        stall,
    output logic        ret_pulse,
    output logic        irq_req
);
    localparam int IDXW = 5;

    cop_op_e         op;
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] mask_q, pend_q, cnt_q, q_rd;
    logic            wake_q, tick;

    assign imm_sx = {{(XLEN-IMMW){imm12[IMMW-1]}}, imm12};

    irq_cop_decode u_decode (
        .valid  (issue_valid),
        .opcode (opcode),
        .funct3 (funct3),
        .funct7 (funct7),
        .op     (op)
    );

    irq_cop_irqctl #(.XLEN(XLEN), .PERM_MASK(PERM_MASK)) u_irqctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_wr     (op == OP_MASK),
        .mask_flip   (rs1_val),
        .mask_keep_n (rs2_val),
        .lines       (irq_lines),
        .ack         (irq_ack),
        .tick        (tick),
        .wait_act    (op == OP_WAIT),
        .mask_q      (mask_q),
        .pend_q      (pend_q),
        .wake_q      (wake_q),
        .irq_req     (irq_req)
    );

    irq_cop_timer #(.XLEN(XLEN)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (op == OP_TIMER),
        .load_val (rs1_val),
        .cnt_q    (cnt_q),
        .fire     (tick)
    );

    irq_cop_qregs #(.XLEN(XLEN), .QNUM(QNUM), .IDXW(IDXW)) u_qregs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (op == OP_QSET),
        .wr_idx (rd_idx),
        .wr_val (rs1_val + imm_sx),
        .rd_idx (rs1_idx),
        .rd_val (q_rd)
    );

    always_comb begin
        rd_data   = '0;
        rd_we     = 1'b0;
        stall     = 1'b0;
        ret_pulse = 1'b0;
        unique case (op)
            OP_MASK:  begin rd_data = mask_q;        rd_we = 1'b1; end
            OP_TIMER: begin rd_data = cnt_q;         rd_we = 1'b1; end
            OP_QGET:  begin rd_data = q_rd + imm_sx; rd_we = 1'b1; end
            OP_WAIT:  begin
                rd_data = pend_q;
                rd_we   = wake_q;
                stall   = !wake_q;
            end
            OP_RET:   ret_pulse = 1'b1;
            default:  ;
        endcase
    end

    // R1
    foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && opcode != OPC_CUSTOM) |-> (!rd_we && !stall && !ret_pulse));

    // R8
    ret_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_pulse |-> (!rd_we && !stall));

    // R5
    stall_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !rd_we);

    // R5
    wait_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && opcode == OPC_CUSTOM && funct3 == F3_RTYPE && funct7 == F7_WAIT && !stall)
        |-> $past(irq_req));
endmodule

// File: tb/irq_cop_tb.sv
`timescale 1ns/1ps
module irq_cop_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid;
    logic [6:0]  opcode;
    logic [2:0]  funct3;
    logic [6:0]  funct7;
    logic [4:0]  rd_idx, rs1_idx;
    logic [11:0] imm12;
    logic [31:0] rs1_val, rs2_val, irq_lines, irq_ack;
    logic [31:0] rd_data;
    logic        rd_we, stall, ret_pulse, irq_req;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    irq_cop u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opcode(opcode),
        .funct3(funct3), .funct7(funct7), .rd_idx(rd_idx), .rs1_idx(rs1_idx),
        .imm12(imm12), .rs1_val(rs1_val), .rs2_val(rs2_val),
        .irq_lines(irq_lines), .irq_ack(irq_ack), .rd_data(rd_data),
        .rd_we(rd_we), .stall(stall), .ret_pulse(ret_pulse), .irq_req(irq_req)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [6:0]  opc;
        logic [2:0]  f3;
        logic [6:0]  f7;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic [11:0] imm;
        logic [31:0] v1;
        logic [31:0] v2;
        logic        we;
        logic [31:0] data;
        logic        ret;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{4'd1,  7'h33, 3'd0, 7'd3, 5'd0, 5'd0, 12'h000, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 32'h0, 1'b0}, // R1 foreign
        '{4'd3,  7'h0b, 3'd0, 7'd3, 5'd1, 5'd2, 12'h000, 32'h0000_00FF, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b0}, // R3 R12
        '{4'd3,  7'h0b, 3'd0, 7'd3, 5'd1, 5'd2, 12'h000, 32'h0000_0F00, 32'h0000_00F0, 1'b1, 32'hC000_00FF, 1'b0}, // R3
        '{4'd4,  7'h0b, 3'd0, 7'd3, 5'd1, 5'd2, 12'h000, 32'hC000_0000, 32'h0000_0000, 1'b1, 32'hC000_0F0F, 1'b0}, // R4
        '{4'd4,  7'h0b, 3'd0, 7'd3, 5'd1, 5'd2, 12'h000, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'hC000_0F0F, 1'b0}, // R4
        '{4'd2,  7'h0b, 3'd0, 7'd6, 5'd1, 5'd2, 12'h000, 32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0, 1'b0}, // R2
        '{4'd9,  7'h0b, 3'd2, 7'd0, 5'd1, 5'd3, 12'hFFF, 32'h0000_0100, 32'h0000_0000, 1'b0, 32'h0, 1'b0}, // R9
        '{4'd9,  7'h0b, 3'd2, 7'd0, 5'd6, 5'd3, 12'h7FF, 32'h0000_1000, 32'h0000_0000, 1'b0, 32'h0, 1'b0}, // R9
        '{4'd10, 7'h0b, 3'd3, 7'd0, 5'd4, 5'd1, 12'h001, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0100, 1'b0}, // R10
        '{4'd10, 7'h0b, 3'd3, 7'd0, 5'd4, 5'd2, 12'h800, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0FFF, 1'b0}, // R10
        '{4'd10, 7'h0b, 3'd3, 7'd0, 5'd4, 5'd5, 12'h000, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_00FF, 1'b0}, // R10
        '{4'd12, 7'h0b, 3'd3, 7'd0, 5'd4, 5'd0, 12'h000, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b0}, // R12
        '{4'd6,  7'h0b, 3'd0, 7'd5, 5'd4, 5'd0, 12'h000, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b0}, // R6
        '{4'd8,  7'h0b, 3'd0, 7'd2, 5'd0, 5'd0, 12'h000, 32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0, 1'b1}, // R8
        '{4'd2,  7'h0b, 3'd1, 7'd3, 5'd4, 5'd0, 12'h000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'h0, 1'b0}, // R2
        '{4'd1,  7'h2b, 3'd2, 7'd0, 5'd0, 5'd0, 12'h000, 32'h0000_0005, 32'h0000_0000, 1'b0, 32'h0, 1'b0}, // R1
        '{4'd1,  7'h0b, 3'd3, 7'd0, 5'd4, 5'd0, 12'h000, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b0}  // R1 q0 kept
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        issue_valid = 1'b0; opcode = '0; funct3 = '0; funct7 = '0;
        rd_idx = '0; rs1_idx = '0; imm12 = '0; rs1_val = '0; rs2_val = '0;
        irq_lines = '0; irq_ack = '0;
    endtask

    task automatic rins(input logic [6:0] f7, input logic [31:0] v1, input logic [31:0] v2);
        idle();
        issue_valid = 1'b1; opcode = 7'h0b; funct3 = 3'd0; funct7 = f7;
        rs1_val = v1; rs2_val = v2;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        // R12 idle outputs after reset
        check("R12 irq_req", {31'd0, irq_req}, 32'd0);
        check("R12 stall", {31'd0, stall}, 32'd0);
        check("R12 rd_we", {31'd0, rd_we}, 32'd0);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            idle();
            issue_valid = 1'b1;
            opcode = TBL[k].opc; funct3 = TBL[k].f3; funct7 = TBL[k].f7;
            rd_idx = TBL[k].rd; rs1_idx = TBL[k].rs1; imm12 = TBL[k].imm;
            rs1_val = TBL[k].v1; rs2_val = TBL[k].v2;
            #1;
            check($sformatf("R%0d we vec%0d", TBL[k].req, k), {31'd0, rd_we}, {31'd0, TBL[k].we});
            check($sformatf("R%0d ret vec%0d", TBL[k].req, k), {31'd0, ret_pulse}, {31'd0, TBL[k].ret});
            check($sformatf("R%0d stall vec%0d", TBL[k].req, k), {31'd0, stall}, 32'd0);
            if (TBL[k].we)
                check($sformatf("R%0d data vec%0d", TBL[k].req, k), rd_data, TBL[k].data);
        end

        // R11 unmasked line raises request one edge later
        @(negedge clk); idle(); irq_lines = 32'h0000_0010;
        @(negedge clk); idle(); #1;
        check("R11 line4 req", {31'd0, irq_req}, 32'd1);
        @(negedge clk); idle(); irq_lines = 32'h0000_0100;
        @(negedge clk); idle(); irq_ack = 32'h0000_0010; #1;
        check("R11 still req", {31'd0, irq_req}, 32'd1);
        @(negedge clk); idle(); #1;
        check("R11 ack clears", {31'd0, irq_req}, 32'd0);

        // R5 wait stalls while only masked lines pend
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); rins(7'd4, 32'd0, 32'd0); #1;
            check("R5 stall held", {31'd0, stall}, 32'd1);
            check("R5 no write", {31'd0, rd_we}, 32'd0);
        end
        @(negedge clk); rins(7'd4, 32'd0, 32'd0); irq_lines = 32'h0000_0020; #1;
        check("R5 stall line cycle", {31'd0, stall}, 32'd1);
        @(negedge clk); rins(7'd4, 32'd0, 32'd0); #1;
        check("R5 stall visible cycle", {31'd0, stall}, 32'd1);
        @(negedge clk); rins(7'd4, 32'd0, 32'd0); #1;
        check("R5 done stall", {31'd0, stall}, 32'd0);
        check("R5 done we", {31'd0, rd_we}, 32'd1);
        check("R5 pending value", rd_data, 32'h0000_0120);

        @(negedge clk); idle(); irq_ack = 32'hFFFF_FFFF;
        @(negedge clk); idle(); #1;
        check("R11 all acked", {31'd0, irq_req}, 32'd0);

        // R4 permanently masked line
        @(negedge clk); idle(); irq_lines = 32'h8000_0000;
        @(negedge clk); idle(); #1;
        check("R4 perm line no req", {31'd0, irq_req}, 32'd0);
        @(negedge clk); rins(7'd3, 32'd0, 32'hFFFF_FFFF); #1;
        check("R3 old mask", rd_data, 32'hC000_0F0F);
        @(negedge clk); rins(7'd3, 32'd0, 32'd0); #1;
        check("R4 mask floor", rd_data, 32'hC000_0000);
        check("R4 pending perm no req", {31'd0, irq_req}, 32'd0);

        // R11 set beats ack
        @(negedge clk); idle(); irq_lines = 32'h0000_0040; irq_ack = 32'h0000_0040;
        @(negedge clk); idle(); #1;
        check("R11 set wins", {31'd0, irq_req}, 32'd1);
        @(negedge clk); idle(); irq_ack = 32'h0000_0040;
        @(negedge clk); idle(); #1;
        check("R11 ack6", {31'd0, irq_req}, 32'd0);

        // R7 countdown from 3
        @(negedge clk); rins(7'd5, 32'd3, 32'd0); #1;
        check("R6 timer old zero", rd_data, 32'd0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); idle(); #1;
            check($sformatf("R7 countdown step%0d", k), {31'd0, irq_req}, (k == 3) ? 32'd1 : 32'd0);
        end
        @(negedge clk); idle(); irq_ack = 32'h0000_0001;
        @(negedge clk); idle(); #1;
        check("R7 fire acked", {31'd0, irq_req}, 32'd0);

        // R7 loading zero disables
        @(negedge clk); rins(7'd5, 32'd10, 32'd0);
        @(negedge clk); rins(7'd5, 32'd0, 32'd0); #1;
        check("R6 timer old ten", rd_data, 32'd10);
        for (int k = 0; k < 15; k++) begin
            @(negedge clk); idle();
        end
        #1;
        check("R7 disabled no fire", {31'd0, irq_req}, 32'd0);
        @(negedge clk); rins(7'd5, 32'd0, 32'd0); #1;
        check("R7 still zero", rd_data, 32'd0);

        // R7 reload at count one suppresses the fire
        @(negedge clk); rins(7'd5, 32'd1, 32'd0);
        @(negedge clk); rins(7'd5, 32'd5, 32'd0); #1;
        check("R6 timer old one", rd_data, 32'd1);
        @(negedge clk); idle(); #1;
        check("R7 reload no fire", {31'd0, irq_req}, 32'd0);
        @(negedge clk); rins(7'd5, 32'd0, 32'd0); #1;
        check("R7 decremented", rd_data, 32'd4);

        // R12 reset restores state
        do_reset();
        @(negedge clk); rins(7'd3, 32'd0, 32'd0); #1;
        check("R12 mask ones", rd_data, 32'hFFFF_FFFF);
        @(negedge clk); idle(); issue_valid = 1'b1; opcode = 7'h0b; funct3 = 3'd3; rs1_idx = 5'd1; #1;
        check("R12 q1 zero", rd_data, 32'd0);
        @(negedge clk); idle(); #1;
        check("R12 pending zero", {31'd0, irq_req}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule